// File: doc/BRIEF.md
# Dirty-Word Write-Back Sequencer

This block holds a small set of write-back cache lines and returns their modified contents to memory. Each line has a 21-bit tag, a valid flag and four 32-bit words. Each word has its own dirty flag. A fill loads a whole line and marks it clean. A store changes one word and sets only that word's dirty flag. A write-back request names one line. It can either keep the line resident (flush) or drop it (eviction).

When a request is accepted, the line's data, tag and set are copied in a single cycle into a line-wide holding buffer, and the line's dirty state is cleared at once. The buffer then drains one 32-bit word per valid/ready handshake. If three or four words were dirty, the whole line goes out as a burst: all four words, lowest offset first, with a burst flag raised. If one or two words were dirty, only those words go out, as single writes. A line with nothing dirty causes no memory traffic at all.

Top module: `dirty_wb_sequencer`

## Requirements
- R1: After reset every line is invalid, `busy` is low and `mem_valid` is low.
- R2: `fill_en` writes `fill_line` into line `fill_set` (word w taken from bits [32w+31:32w]), stores `fill_tag`, sets the line valid and clears all four of its dirty flags.
- R3: `st_en` on a valid line writes `st_data` into word `st_word` (0 to 3) and sets that word's dirty flag only. A store to an invalid line is ignored.
- R4: An accepted request on a valid line with three or four dirty words emits all four words at offsets 0, 4, 8, 12 in that order, with `mem_burst` high on every one.
- R5: An accepted request with one or two dirty words emits only the dirty words, lowest offset first, with `mem_burst` low. Clean words are skipped.
- R6: A request on a line that is invalid or has no dirty word produces no memory write, and `busy` stays low.
- R7: The address of each word is {tag[20:0], set zero-extended to 7 bits, word index[1:0], 2'b00}. The data is the word's value at the cycle the request was accepted, even if the line is stored to afterwards.
- R8: A presented word, with its address and data, stays unchanged until a cycle with `mem_valid` and `mem_ready` both high. Each such cycle retires exactly one word.
- R9: `busy` rises in the cycle after a request that has words to write is accepted. It falls after the handshake of the last word. A request while `busy` is high is ignored, and the line keeps its dirty state.
- R10: On acceptance the line's dirty flags are cleared. When `wb_evict` is 1 the line is also made invalid; when it is 0 the line stays valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fill_en | input | 1 | Load a whole line |
| fill_set | input | 2 | Line index for fill |
| fill_tag | input | 21 | Tag for the filled line |
| fill_line | input | 128 | Line data, word 0 in low bits |
| st_en | input | 1 | Store one word |
| st_set | input | 2 | Line index for store |
| st_word | input | 2 | Word index within the line |
| st_data | input | 32 | Store data |
| wb_req | input | 1 | Write-back request |
| wb_set | input | 2 | Line index for write-back |
| wb_evict | input | 1 | 1 = evict (invalidate), 0 = flush |
| busy | output | 1 | Buffer holds undrained words |
| mem_valid | output | 1 | Word presented to memory |
| mem_ready | input | 1 | Memory accepts the presented word |
| mem_addr | output | 32 | Byte address of the word |
| mem_data | output | 32 | Word data |
| mem_burst | output | 1 | Word is part of a full-line burst |

## Verification
Corrupt dirty flags show up at the ports as an extra, missing or reordered memory write, or a wrong `mem_burst` level. This appears on the next accepted write-back of that line, typically within one to five cycles of the request. A buffer that fails to snapshot, or that drains wrongly, shows a wrong address or data word on the very cycle it is presented. A stuck or early-cleared pending state shows as a `busy` level that disagrees with the expected write count. The bench compares `busy`, `mem_valid`, address, data and burst flag against its model every cycle. This keeps the distance between fault and detection to a single clock.

// File: rtl/wbseq_pkg.sv
package wbseq_pkg;
  typedef struct packed {
    logic capture;     // copy line into buffer
    logic burst;       // send whole line as burst
    logic clean;       // clear dirty flags of requested line
    logic invalidate;  // clear valid flag of requested line
  } wb_strobe_t;
endpackage

// File: rtl/wbseq_ctrl.sv
module wbseq_ctrl
  import wbseq_pkg::*;
#(
  parameter int WORDS     = 4,
  parameter int BURST_MIN = 3
) (
  input  logic             wbReq,
  input  logic             wbEvict,
  input  logic             lineValid,
  input  logic [WORDS-1:0] lineDirty,
  input  logic             busy,
  output wb_strobe_t       strobe
);
  localparam int CNT_W = $clog2(WORDS + 1);

  logic [CNT_W-1:0] dirtyCount;
  logic             accept;

  always_comb begin
    dirtyCount = '0;
    for (int i = 0; i < WORDS; i++) dirtyCount = dirtyCount + CNT_W'(lineDirty[i]);
  end

  assign accept = wbReq && !busy;

  always_comb begin
    strobe            = '0;
    strobe.clean      = accept;
    strobe.invalidate = accept && wbEvict;
    strobe.capture    = accept && lineValid && (dirtyCount != '0);
    strobe.burst      = dirtyCount >= CNT_W'(BURST_MIN);
  end
endmodule

// File: rtl/wbseq_dpath.sv
module wbseq_dpath
  import wbseq_pkg::*;
#(
  parameter int LINES     = 4,
  parameter int WORDS     = 4,
  parameter int WORD_W    = 32,
  parameter int TAG_W     = 21,
  parameter int ADDR_W    = 32,
  parameter int BURST_MIN = 3
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    fillEn,
  input  logic [$clog2(LINES)-1:0] fillSet,
  input  logic [TAG_W-1:0]        fillTag,
  input  logic [WORDS*WORD_W-1:0] fillLine,
  input  logic                    stEn,
  input  logic [$clog2(LINES)-1:0] stSet,
  input  logic [$clog2(WORDS)-1:0] stWord,
  input  logic [WORD_W-1:0]       stData,
  input  logic [$clog2(LINES)-1:0] wbSet,
  input  wb_strobe_t              strobe,
  input  logic                    memReady,
  output logic                    lineValid,
  output logic [WORDS-1:0]        lineDirty,
  output logic                    busy,
  output logic                    memValid,
  output logic [ADDR_W-1:0]       memAddr,
  output logic [WORD_W-1:0]       memData,
  output logic                    memBurst
);
  localparam int SET_W  = $clog2(LINES);
  localparam int WIDX_W = $clog2(WORDS);
  localparam int OFF_W  = $clog2(WORDS * WORD_W / 8);
  localparam int SETF_W = ADDR_W - TAG_W - OFF_W;

  logic [TAG_W-1:0]  tagArr   [LINES];
  logic [WORD_W-1:0] dataArr  [LINES][WORDS];
  logic [LINES-1:0]  validArr;
  logic [WORDS-1:0]  dirtyArr [LINES];

  logic [WORD_W-1:0] bufData [WORDS];
  logic [TAG_W-1:0]  bufTag;
  logic [SET_W-1:0]  bufSet;
  logic [WORDS-1:0]  pending;
  logic              bufBurst;
  logic [WIDX_W-1:0] popIdx;
  logic              pop;

  // line state flags
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      validArr <= '0;
      for (int l = 0; l < LINES; l++) dirtyArr[l] <= '0;
    end else begin
      if (strobe.clean)      dirtyArr[wbSet] <= '0;
      if (strobe.invalidate) validArr[wbSet] <= 1'b0;
      if (stEn && validArr[stSet]) dirtyArr[stSet][stWord] <= 1'b1;
      if (fillEn) begin
        validArr[fillSet] <= 1'b1;
        dirtyArr[fillSet] <= '0;
      end
    end
  end

  // line contents
  always_ff @(posedge clk) begin
    if (stEn && validArr[stSet]) dataArr[stSet][stWord] <= stData;
    if (fillEn) begin
      tagArr[fillSet] <= fillTag;
      for (int w = 0; w < WORDS; w++) dataArr[fillSet][w] <= fillLine[w*WORD_W +: WORD_W];
    end
  end

  assign lineValid = validArr[wbSet];
  assign lineDirty = dirtyArr[wbSet];

  // lowest pending word goes first
  always_comb begin
    popIdx = '0;
    for (int w = WORDS - 1; w >= 0; w--) if (pending[w]) popIdx = WIDX_W'(w);
  end

  assign busy     = |pending;
  assign memValid = busy;
  assign pop      = memValid && memReady;
  assign memBurst = busy && bufBurst;
  assign memData  = bufData[popIdx];
  assign memAddr  = {bufTag, SETF_W'(bufSet), popIdx, {(OFF_W - WIDX_W){1'b0}}};

  // flush buffer
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pending  <= '0;
      bufBurst <= 1'b0;
    end else if (strobe.capture) begin
      pending  <= strobe.burst ? '1 : dirtyArr[wbSet];
      bufBurst <= strobe.burst;
    end else if (pop) begin
      pending[popIdx] <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (strobe.capture) begin
      bufTag <= tagArr[wbSet];
      bufSet <= wbSet;
      for (int w = 0; w < WORDS; w++) bufData[w] <= dataArr[wbSet][w];
    end
  end

  assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    memValid && !memReady |=> memValid && $stable(memAddr) && $stable(memData));

  assert_refuse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !memReady |=> $stable(pending));

  assert_burst_order_R4: assert property (@(posedge clk) disable iff (!rst_n)
    pop && memBurst && (popIdx != WIDX_W'(WORDS - 1))
    |=> memBurst && (popIdx == $past(popIdx) + WIDX_W'(1)));

  assert_sparse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    memValid && !memBurst |-> $countones(pending) < BURST_MIN);

  assert_clean_R10: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.clean && !(stEn && stSet == wbSet) && !(fillEn && fillSet == wbSet)
    |=> dirtyArr[$past(wbSet)] == '0);
endmodule

// File: rtl/dirty_wb_sequencer.sv
module dirty_wb_sequencer
  import wbseq_pkg::*;
#(
  parameter int LINES     = 4,
  parameter int WORDS     = 4,
  parameter int WORD_W    = 32,
  parameter int TAG_W     = 21,
  parameter int ADDR_W    = 32,
  parameter int BURST_MIN = 3
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      fill_en,
  input  logic [$clog2(LINES)-1:0]  fill_set,
  input  logic [TAG_W-1:0]          fill_tag,
  input  logic [WORDS*WORD_W-1:0]   fill_line,
  input  logic                      st_en,
  input  logic [$clog2(LINES)-1:0]  st_set,
  input  logic [$clog2(WORDS)-1:0]  st_word,
  input  logic [WORD_W-1:0]         st_data,
  input  logic                      wb_req,
  input  logic [$clog2(LINES)-1:0]  wb_set,
  input  logic                      wb_evict,
  output logic                      busy,
  output logic                      mem_valid,
  input  logic                      mem_ready,
  output logic [ADDR_W-1:0]         mem_addr,
  output logic [WORD_W-1:0]         mem_data,
  output logic                      mem_burst
);
  wb_strobe_t       strobe;
  logic             lineValid;
  logic [WORDS-1:0] lineDirty;

  wbseq_ctrl #(.WORDS(WORDS), .BURST_MIN(BURST_MIN)) ctrl (
    .wbReq(wb_req), .wbEvict(wb_evict), .lineValid(lineValid),
    .lineDirty(lineDirty), .busy(busy), .strobe(strobe)
  );

  wbseq_dpath #(
    .LINES(LINES), .WORDS(WORDS), .WORD_W(WORD_W), .TAG_W(TAG_W),
    .ADDR_W(ADDR_W), .BURST_MIN(BURST_MIN)
  ) dpath (
    .clk(clk), .rst_n(rst_n),
    .fillEn(fill_en), .fillSet(fill_set), .fillTag(fill_tag), .fillLine(fill_line),
    .stEn(st_en), .stSet(st_set), .stWord(st_word), .stData(st_data),
    .wbSet(wb_set), .strobe(strobe), .memReady(mem_ready),
    .lineValid(lineValid), .lineDirty(lineDirty), .busy(busy),
    .memValid(mem_valid), .memAddr(mem_addr), .memData(mem_data), .memBurst(mem_burst)
  );
endmodule

// File: tb/dirty_wb_sequencer_test.sv
module dirty_wb_sequencer_test;
  logic clk = 0, rst_n = 0;
  logic fill_en = 0, st_en = 0, wb_req = 0, wb_evict = 0, mem_ready = 1;
  logic [1:0] fill_set = 0, st_set = 0, st_word = 0, wb_set = 0;
  logic [20:0] fill_tag = 0;
  logic [127:0] fill_line = 0;
  logic [31:0] st_data = 0;
  logic busy, mem_valid, mem_burst;
  logic [31:0] mem_addr, mem_data;

  dirty_wb_sequencer uut (.*);

  always #4 clk = ~clk;

  typedef struct { logic [31:0] a; logic [31:0] d; bit b; } xfer_t;
  xfer_t q[$];
  bit [20:0] mTag[4];
  bit        mValid[4];
  bit [3:0]  mDirty[4];
  bit [31:0] mData[4][4];

  int checks = 0, errors = 0, cycle = 0, readyMode = 0;
  string curReq = "R1";
  bit done = 0;

  // reference model
  always @(posedge clk) begin
    if (!rst_n) begin
      q.delete();
      for (int l = 0; l < 4; l++) begin mValid[l] = 0; mDirty[l] = 0; end
    end else begin
      bit wasBusy;
      bit vSnap[4];
      wasBusy = q.size() != 0;
      for (int l = 0; l < 4; l++) vSnap[l] = mValid[l];
      if (wasBusy && mem_ready) void'(q.pop_front());
      if (wb_req && !wasBusy) begin
        int cnt;
        cnt = 0;
        for (int w = 0; w < 4; w++) cnt += mDirty[wb_set][w];
        if (mValid[wb_set] && cnt > 0)
          for (int w = 0; w < 4; w++)
            if (cnt >= 3 || mDirty[wb_set][w]) begin
              xfer_t x;
              x.a = {mTag[wb_set], 5'd0, wb_set, w[1:0], 2'b00};
              x.d = mData[wb_set][w];
              x.b = cnt >= 3;
              q.push_back(x);
            end
        mDirty[wb_set] = 0;
        if (wb_evict) mValid[wb_set] = 0;
      end
      if (st_en && vSnap[st_set]) begin
        mData[st_set][st_word] = st_data;
        mDirty[st_set][st_word] = 1;
      end
      if (fill_en) begin
        mTag[fill_set] = fill_tag;
        mValid[fill_set] = 1;
        mDirty[fill_set] = 0;
        for (int w = 0; w < 4; w++) mData[fill_set][w] = fill_line[w*32 +: 32];
      end
    end
  end

  // per-cycle comparison away from the active edge
  always @(negedge clk) begin
    cycle++;
    if (rst_n && !done) begin
      bit expV;
      expV = q.size() != 0;
      checks++;
      if (busy !== expV || mem_valid !== expV) begin
        errors++;
        $display("FAIL %s busy/valid actual=%b/%b expected=%b", curReq, busy, mem_valid, expV);
      end else if (expV) begin
        checks++;
        if (mem_addr !== q[0].a || mem_data !== q[0].d || mem_burst !== q[0].b) begin
          errors++;
          $display("FAIL %s word actual=%h/%h/%b expected=%h/%h/%b", curReq,
                   mem_addr, mem_data, mem_burst, q[0].a, q[0].d, q[0].b);
        end
      end
    end
    mem_ready = (readyMode == 0) ? 1'b1 : (cycle % 3 != 0);
  end

  task automatic step(); @(negedge clk); #1; endtask
  task automatic clr(); fill_en = 0; st_en = 0; wb_req = 0; wb_evict = 0; endtask

  task automatic doFill(input logic [1:0] s, input logic [20:0] t);
    fill_en = 1; fill_set = s; fill_tag = t;
    for (int w = 0; w < 4; w++) fill_line[w*32 +: 32] = {8'hA0 + 8'(s), t[15:0], 8'(w)};
    step(); clr();
  endtask
  task automatic doStore(input logic [1:0] s, input logic [1:0] w, input logic [31:0] d);
    st_en = 1; st_set = s; st_word = w; st_data = d; step(); clr();
  endtask
  task automatic doWb(input logic [1:0] s, input bit ev);
    wb_req = 1; wb_set = s; wb_evict = ev; step(); clr();
  endtask
  task automatic idle(input int n); for (int i = 0; i < n; i++) step(); endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #1 rst_n = 1;
    step();
    curReq = "R1"; checks++;
    if (busy !== 0 || mem_valid !== 0) begin
      errors++; $display("FAIL R1 actual=%b%b expected=00", busy, mem_valid);
    end
    curReq = "R2"; for (int l = 0; l < 4; l++) doFill(l[1:0], 21'h1_2340 + 21'(l * 7));
    curReq = "R6"; doWb(0, 0); idle(3); doWb(3, 0); idle(3);
    curReq = "R5"; doStore(1, 2, 32'hDEAD_0001); doWb(1, 0); idle(4);
    doStore(2, 3, 32'h3333_0003); doStore(2, 0, 32'h0000_1110); doWb(2, 0); idle(5);
    curReq = "R4"; doStore(3, 1, 32'h1); doStore(3, 2, 32'h2); doStore(3, 3, 32'h3);
    doWb(3, 0); idle(6);
    for (int w = 0; w < 4; w++) doStore(0, w[1:0], 32'hF00D_0000 + 32'(w));
    doWb(0, 0); idle(6);
    curReq = "R8"; readyMode = 1;
    for (int w = 0; w < 4; w++) doStore(1, w[1:0], 32'hBEEF_0000 + 32'(w));
    doWb(1, 0); idle(10);
    doStore(2, 1, 32'h5); doWb(2, 0); idle(6);
    curReq = "R9"; doStore(0, 0, 32'hAB); doStore(0, 2, 32'hCD); doStore(3, 0, 32'h77);
    doWb(0, 0); doWb(3, 0); idle(8);
    doWb(3, 0); idle(6);
    curReq = "R7"; readyMode = 0;
    doStore(1, 0, 32'h11); doStore(1, 1, 32'h22); doStore(1, 2, 32'h33);
    doWb(1, 0); doStore(1, 0, 32'h99); idle(6); doWb(1, 0); idle(4);
    curReq = "R10"; doWb(1, 0); idle(3);
    doStore(2, 2, 32'h42); doWb(2, 1); idle(4);
    curReq = "R3"; doStore(2, 2, 32'h43); doWb(2, 0); idle(3);
    doFill(2, 21'h1F_FFFF); doStore(2, 3, 32'h44); doWb(2, 1); idle(4);
    curReq = "R1"; rst_n = 0; step(); step(); rst_n = 1; step();
    doWb(1, 0); idle(3);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule